// File: doc/BRIEF.md
# Selectable Divide-by-3/4 Clock Fanout

This block takes one reference clock and produces a divided clock whose ratio is chosen at run time: three or four reference periods per output period. Both ratios keep the output at an even 50% duty. For the odd ratio, a copy retimed on the falling edge fills in the missing half period.

The divided clock fans out to four output pins arranged as two banks of two. Each bank has its own active-high enable. A disabled bank releases its pins to high impedance, so another driver or a pull resistor on the board decides their level.

The ratio select and both enables read as logic 1 when they are left floating. An unconnected block therefore comes up dividing by four with every pin driving. A ratio change never cuts a phase short, because the new ratio is taken only at the rising edge that starts a new output period. An active-low asynchronous reset forces the divided clock low. The first rising reference edge after reset is released starts a high phase.

Top module: `clkdiv34_fanout`

## Requirements
- R1: With `ratio_sel` at 0, the divided clock is high for 3 reference half-periods and then low for 3, repeating.
- R2: With `ratio_sel` at 1, the divided clock is high for 4 reference half-periods and then low for 4, repeating. The falling-edge extension stays inactive.
- R3: `ratio_sel` is sampled only at the rising reference edge that begins a new output period. A change in the middle of a period finishes the current period at the old ratio.
- R4: While a bank stays enabled, every high or low phase on its pins lasts at least 3 reference half-periods, including across ratio changes.
- R5: `bank_en[0]` drives `clk_out[0]` and `clk_out[1]`. When it is 0, both pins are high impedance; when it is 1, both carry the divided clock.
- R6: `bank_en[1]` drives `clk_out[2]` and `clk_out[3]` in the same way. The two enables act independently in all four combinations.
- R7: Every pin that is driving carries the same divided clock, with no offset between pins.
- R8: A floating (high-impedance) or unknown `ratio_sel` or `bank_en` bit is treated as 1.
- R9: While `rst_n` is 0, the divided clock is low. The first rising `ref_clk` edge after release starts a high phase at the ratio selected at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 1 | 0 selects divide-by-3, 1 (or floating) selects divide-by-4 |
| bank_en | input | NBANK (2) | Per-bank output enable, 1 (or floating) drives |
| clk_out | output | NBANK*PER_BANK (4) | Divided clock pins; bank b owns bits [b*PER_BANK +: PER_BANK] |

## Verification
A wrong counter or ratio register shows up at the pins as a high or low phase of the wrong length. The reference model compares every half-period, so the mismatch appears within one output period. A ratio latched at the wrong edge shows up as a shortened or stretched phase right after a select change. The falling-edge stage enabled at the wrong time shows up half a reference period later as an extra half-period of high. An enable fault shows up immediately as a pin that is driving while it should float, or floating while it should drive.

// File: rtl/clkdiv34_pkg.sv
package clkdiv34_pkg;
    localparam int CNT_W = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;   // position within the output period
        logic             div4;  // ratio in force: 1 = four, 0 = three
        logic             hi;    // rising-edge part of the divided clock
    } div_state_t;

    localparam logic [CNT_W-1:0] LAST_DIV3 = CNT_W'(2);
    localparam logic [CNT_W-1:0] LAST_DIV4 = CNT_W'(3);
    localparam logic [CNT_W-1:0] HALF_DIV4 = CNT_W'(2);
endpackage

// File: rtl/div34_rise_core.sv
module div34_rise_core
    import clkdiv34_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel4,
    output logic [CNT_W-1:0] cnt,
    output logic             div4,
    output logic             hi
);
    div_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        wrap = st_q.div4 ? (st_q.cnt == LAST_DIV4) : (st_q.cnt == LAST_DIV3);
        if (wrap) begin
            st_d.cnt  = '0;
            st_d.div4 = sel4;           // new ratio only at a period boundary
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
        st_d.hi = st_d.div4 ? (st_d.cnt < HALF_DIV4) : (st_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= LAST_DIV4;     // first edge after reset wraps
            st_q.div4 <= 1'b1;
            st_q.hi   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign div4 = st_q.div4;
    assign hi   = st_q.hi;
endmodule

// File: rtl/div34_fall_ext.sv
module div34_fall_ext (
    input  logic clk,
    input  logic rst_n,
    input  logic hi,
    input  logic div4,
    output logic ext
);
    logic ext_d, ext_q;

    always_comb begin
        ext_d = hi & ~div4;             // half-period stretch only for ratio three
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_d;
    end

    assign ext = ext_q;
endmodule

// File: rtl/bank_tristate.sv
module bank_tristate #(
    parameter int WIDTH = 2
) (
    input  logic             en,
    input  logic             clk_in,
    output logic [WIDTH-1:0] pins
);
    assign pins = en ? {WIDTH{clk_in}} : {WIDTH{1'bz}};
endmodule

// File: rtl/clkdiv34_fanout.sv
module clkdiv34_fanout
    import clkdiv34_pkg::*;
#(
    parameter int NBANK    = 2,
    parameter int PER_BANK = 2,
    localparam int NPIN    = NBANK * PER_BANK
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             ratio_sel,
    input  logic [NBANK-1:0] bank_en,
    output logic [NPIN-1:0]  clk_out
);
    logic             sel4;
    logic [NBANK-1:0] en_eff;
    logic [CNT_W-1:0] div_cnt;
    logic             div4;
    logic             div_hi;
    logic             div_ext;
    logic             div_clk;

    // floating or unknown control pins read as 1
    always_comb begin
        sel4 = (ratio_sel !== 1'b0);
        for (int b = 0; b < NBANK; b++) begin
            en_eff[b] = (bank_en[b] !== 1'b0);
        end
    end

    div34_rise_core u_core (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .sel4  (sel4),
        .cnt   (div_cnt),
        .div4  (div4),
        .hi    (div_hi)
    );

    div34_fall_ext u_ext (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .hi    (div_hi),
        .div4  (div4),
        .ext   (div_ext)
    );

    assign div_clk = div_hi | div_ext;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_tristate #(.WIDTH(PER_BANK)) u_bank (
            .en     (en_eff[b]),
            .clk_in (div_clk),
            .pins   (clk_out[b*PER_BANK +: PER_BANK])
        );
    end
endmodule

// File: rtl/clkdiv34_checker.sv
module clkdiv34_checker
    import clkdiv34_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             div4,
    input logic             hi,
    input logic             ext
);
    // R1: ratio three never reaches the fourth count
    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !div4 |-> (cnt != LAST_DIV4));

    // R3: the ratio register changes only where a new period starts high
    assert_ratio_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div4 != $past(div4)) |-> (cnt == '0 && hi));

    // R4: a high phase begins only at count zero
    assert_hi_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi) |-> (cnt == '0));

    // R2: the falling-edge stretch stays off for ratio four
    assert_ext_off_div4_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div4 |-> !ext);

    // R9: both halves of the divided clock are low under reset
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R9: assert (!hi && !ext);
        end
    end
endmodule

bind clkdiv34_fanout clkdiv34_checker u_chk (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .cnt   (div_cnt),
    .div4  (div4),
    .hi    (div_hi),
    .ext   (div_ext)
);

// File: tb/clkdiv34_fanout_tb.sv
`timescale 1ns/1ps
module clkdiv34_fanout_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_val = 1'b1, sel_drv = 1'b0;
    logic [1:0] en_val = 2'b11, en_drv = 2'b11;
    wire        sel_w;
    wire  [1:0] en_w;
    wire  [3:0] pin_w;

    // board-level pull-ups: floating pins read 1
    pullup pu_sel (sel_w);
    assign sel_w = sel_drv ? sel_val : 1'bz;
    for (genvar i = 0; i < 2; i++) begin : g_en
        pullup pu_en (en_w[i]);
        assign en_w[i] = en_drv[i] ? en_val[i] : 1'bz;
    end
    for (genvar i = 0; i < 4; i++) begin : g_pin
        pullup pu_pin (pin_w[i]);
    end

    always #4 clk = ~clk;   // 125 MHz

    clkdiv34_fanout u_dut (
        .ref_clk   (clk),
        .rst_n     (rst_n),
        .ratio_sel (sel_w),
        .bank_en   (en_w),
        .clk_out   (pin_w)
    );

    int    vectors = 0, fails = 0;
    bit    done = 0;
    string tag = "R9";
    // behavioural reference: position in half-periods within the output period
    bit    started = 0;
    int    pos = 0, ratio = 4;
    // run-length watch on pin 0
    int    run_len = 0;
    bit    run_valid = 0, last_obs = 0;

    function automatic bit sel_eff(); return sel_drv ? sel_val : 1'b1; endfunction
    function automatic bit en_eff(int b); return en_drv[b] ? en_val[b] : 1'b1; endfunction

    task automatic check(bit ok, string t, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    task automatic half(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk or negedge clk);
            if (rst_n) begin
                if (started) pos++;
                if (clk && (!started || pos == 2 * ratio)) begin
                    started = 1; pos = 0; ratio = sel_eff() ? 4 : 3;
                end
            end else begin
                started = 0; pos = 0;
            end
            #2;
            begin
                bit divx = started && (pos < ratio);
                for (int p = 0; p < 4; p++) begin
                    bit    exp = en_eff(p / 2) ? divx : 1'b1;   // disabled pin floats to pull-up
                    string t   = !rst_n ? "R9" : (!en_eff(p / 2) ? (p < 2 ? "R5" : "R6") : tag);
                    check(pin_w[p] === exp, t, $sformatf("pin %0d", p), pin_w[p], exp);
                end
                if (en_eff(0) && en_eff(1))   // R7: all driving pins identical
                    check(pin_w == {4{pin_w[0]}}, "R7", "pin match", pin_w, {4{pin_w[0]}});
                // R4: no phase shorter than three half-periods on an enabled bank
                if (!rst_n || !en_eff(0)) begin
                    run_valid = 0; run_len = 0;
                end else if (pin_w[0] == last_obs) begin
                    run_len++;
                end else begin
                    if (run_valid)
                        check(run_len >= 3 && run_len <= 4, "R4", "phase length", run_len, 3);
                    run_valid = 1; run_len = 1;
                end
                last_obs = pin_w[0];
            end
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        tag = "R9"; half(6);                                   // reset state, all floating defaults
        rst_n = 1'b1;
        tag = "R8"; half(32);                                  // floating select: divide by four
        sel_drv = 1'b1; sel_val = 1'b0; tag = "R1"; half(48);  // divide by three
        sel_val = 1'b1; tag = "R2"; half(40);                  // divide by four, driven
        tag = "R3";                                            // select changes at many phases
        for (int i = 0; i < 14; i++) begin
            sel_val = ~sel_val; half(5 + (i % 4));
        end
        sel_val = 1'b0; tag = "R1";
        for (int c = 0; c < 4; c++) begin                      // R5 / R6 enable combinations
            en_val = 2'(c); half(18);
        end
        en_val = 2'b00; en_drv = 2'b00; tag = "R8"; half(16);  // floating enables drive
        en_drv = 2'b11; en_val = 2'b11; sel_val = 1'b1; tag = "R2"; half(11);
        rst_n = 1'b0; half(6);                                 // R9 mid-run reset
        rst_n = 1'b1; sel_val = 1'b0; tag = "R9"; half(24);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule